// File: doc/BRIEF.md
# Battery Switchover and Chip-Enable Gating Controller

This block picks the power source for a memory rail and guards the memory chip-enable while the main supply is unreliable. Digitized comparator flags report whether the main supply is under the reset threshold, under the battery voltage, and under roughly 4 V. When both of the first two hold, the block moves the rail to the battery and raises its battery-on indicator. While on battery, the status lines that feed the rest of the system are forced to safe levels. The manual-reset and watchdog inputs are masked, and the low-line, power-fail and battery-good flags are pulled low.

The chip-enable path follows the system reset. Once reset has been high for a set number of clock cycles, the gated chip-enable is held at its inactive high level. If reset drops before that count completes, the pending cut is cancelled. After the block's own reset, and after any cut, the path stays closed until the system reset is seen low. That low comes only after the reset timeout has run out.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: `batt_on` is high in a cycle only if, at the preceding clock edge, both `sup_lo_rst` and `sup_lo_batt` were high. Entry into backup takes exactly one edge.
- R2: At any edge where `sup_lo_rst` or `sup_lo_batt` is low, `batt_on` goes low on that same edge.
- R3: While the gate is open, `CUT_DLY` consecutive edges that sample `sys_rst` high close it on the last of those edges.
- R4: An edge that samples `sys_rst` low while the gate is open resets the count, so a reset shorter than `CUT_DLY` edges never closes the gate.
- R5: After `rst_n` and after any closure, the gate reopens only on an edge that samples `sys_rst` low.
- R6: When the gate is closed, `ce_out_n` is 1. When it is open, `ce_out_n` equals `ce_in_n`. Both are active low.
- R7: While `batt_on` is high, `mr_out_n` is 1 whatever `mr_in_n` does. Otherwise it equals `mr_in_n`.
- R8: While `batt_on` is high, `wdi_out` holds the `wdi_in` value sampled at the edge that entered backup. Otherwise it equals `wdi_in`.
- R9: While `batt_on` and `sup_lo_4v` are both high, `pfo_out` and `bok_out` are 0. Otherwise they equal `pfo_in` and `bok_in`.
- R10: While `batt_on` is high, `lowline_out` is 0. Otherwise it equals `lowline_in`.
- R11: While `rst_n` is low, `batt_on` is 0 and the gate is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | asynchronous active-low reset of the block |
| sup_lo_rst | input | 1 | supply under reset threshold |
| sup_lo_batt | input | 1 | supply under battery voltage |
| sup_lo_4v | input | 1 | supply under about 4 V |
| sys_rst | input | 1 | system reset state, high while asserted |
| ce_in_n | input | 1 | incoming chip-enable, active low |
| mr_in_n | input | 1 | manual reset request, active low |
| wdi_in | input | 1 | watchdog input |
| pfo_in | input | 1 | raw power-fail flag |
| bok_in | input | 1 | raw battery-good flag |
| lowline_in | input | 1 | raw low-line flag |
| batt_on | output | 1 | rail fed from battery |
| ce_out_n | output | 1 | gated chip-enable, active low |
| mr_out_n | output | 1 | masked manual reset |
| wdi_out | output | 1 | masked watchdog input |
| pfo_out | output | 1 | forced power-fail flag |
| bok_out | output | 1 | forced battery-good flag |
| lowline_out | output | 1 | forced low-line flag |

## Verification
Two events can land on the same edge: the last edge of the cut delay, and the drop of `sys_rst` that would cancel it. The bench provokes this by holding reset for exactly `CUT_DLY` edges and, separately, for one edge fewer. It judges the gated chip-enable against a behavioural model that counts consecutive high samples. A second coincidence is backup entry on the edge where `wdi_in` changes. The bench provokes it by flipping both at once, and it checks that the held watchdog value is the one sampled on that entry edge.

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl #(
  parameter int CUT_DLY = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_lo_rst,
  input  logic sup_lo_batt,
  input  logic sup_lo_4v,
  input  logic sys_rst,
  input  logic ce_in_n,
  input  logic mr_in_n,
  input  logic wdi_in,
  input  logic pfo_in,
  input  logic bok_in,
  input  logic lowline_in,
  output logic batt_on,
  output logic ce_out_n,
  output logic mr_out_n,
  output logic wdi_out,
  output logic pfo_out,
  output logic bok_out,
  output logic lowline_out
);
  localparam int CW = $clog2(CUT_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(CUT_DLY - 1);

  logic          bmode;
  logic          gate_open;
  logic [CW-1:0] cnt;
  logic          wdi_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmode    <= 1'b0;
      wdi_hold <= 1'b0;
    end else begin
      bmode <= sup_lo_rst & sup_lo_batt;
      if (!bmode) wdi_hold <= wdi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_open <= 1'b0;
      cnt       <= '0;
    end else if (gate_open) begin
      if (!sys_rst) cnt <= '0;
      else if (cnt == LAST) begin
        gate_open <= 1'b0;
        cnt       <= '0;
      end else cnt <= cnt + 1'b1;
    end else if (!sys_rst) begin
      gate_open <= 1'b1;
    end
  end

  assign batt_on     = bmode;
  assign ce_out_n    = gate_open ? ce_in_n : 1'b1;
  assign mr_out_n    = bmode | mr_in_n;
  assign wdi_out     = bmode ? wdi_hold : wdi_in;
  assign pfo_out     = (bmode & sup_lo_4v) ? 1'b0 : pfo_in;
  assign bok_out     = (bmode & sup_lo_4v) ? 1'b0 : bok_in;
  assign lowline_out = bmode ? 1'b0 : lowline_in;

  AST_BATT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_on) |-> $past(sup_lo_rst && sup_lo_batt)); // R1
  AST_BATT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sup_lo_rst && sup_lo_batt) |=> !batt_on); // R2
  AST_OPEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && !sys_rst) |=> gate_open); // R4
  AST_REOPEN_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> $past(!sys_rst)); // R5
  AST_CLOSED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !ce_in_n) |-> ce_out_n); // R6
  AST_MR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    batt_on |-> mr_out_n); // R7
  AST_CUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && sys_rst && cnt == LAST) |=> !gate_open); // R3
endmodule

// File: tb/tb_bkup_switch_ctrl.sv
module tb_bkup_switch_ctrl;
  localparam int TCLK = 10;
  localparam int DLY  = 6;

  logic clk = 0, rst_n = 0;
  logic sup_lo_rst = 0, sup_lo_batt = 0, sup_lo_4v = 0, sys_rst = 1;
  logic ce_in_n = 0, mr_in_n = 1, wdi_in = 0, pfo_in = 1, bok_in = 1, lowline_in = 1;
  logic batt_on, ce_out_n, mr_out_n, wdi_out, pfo_out, bok_out, lowline_out;

  int errors = 0, checks = 0, cyc = 0;
  bit m_b = 0, m_open = 0, m_hold = 0, done = 0;
  int m_run = 0;
  string ce_tag = "R11";

  bkup_switch_ctrl #(.CUT_DLY(DLY)) dut (.*);

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_b = 0; m_open = 0; m_run = 0; ce_tag = "R11";
    end else begin
      if (!m_b) m_hold = wdi_in;
      m_b = sup_lo_rst && sup_lo_batt;
      if (m_open) begin
        if (sys_rst) begin
          m_run++;
          if (m_run >= DLY) begin m_open = 0; m_run = 0; ce_tag = "R3"; end
          else ce_tag = "R4";
        end else begin
          if (m_run > 0) ce_tag = "R4"; else ce_tag = "R6";
          m_run = 0;
        end
      end else if (!sys_rst) begin
        m_open = 1; ce_tag = "R5";
      end else ce_tag = "R5";
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_b ? "R1" : "R2", batt_on, m_b);
    chk(ce_tag, ce_out_n, m_open ? ce_in_n : 1'b1);
    chk("R7", mr_out_n, m_b ? 1'b1 : mr_in_n);
    chk("R8", wdi_out, m_b ? m_hold : wdi_in);
    chk("R9", pfo_out, (m_b && sup_lo_4v) ? 1'b0 : pfo_in);
    chk("R9", bok_out, (m_b && sup_lo_4v) ? 1'b0 : bok_in);
    chk("R10", lowline_out, m_b ? 1'b0 : lowline_in);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic rst_pulse(int len);
    @(negedge clk); sys_rst = 1;
    step(len);
    sys_rst = 0;
    step(3);
  endtask

  initial begin
    #1;
    // R11 reset state
    step(3);
    rst_n = 1;
    step(4);
    sys_rst = 0;
    step(3);
    // R4 cancel one edge short, R3 exactly at delay
    rst_pulse(DLY - 1);
    rst_pulse(DLY);
    rst_pulse(DLY + 4);
    rst_pulse(1);
    // R1, R8 entry with simultaneous wdi change
    wdi_in = 1; sup_lo_rst = 1; sup_lo_batt = 1; sys_rst = 1;
    step(2);
    wdi_in = 0; mr_in_n = 0; lowline_in = 1; sup_lo_4v = 1;
    step(3);
    sup_lo_4v = 0; step(2);
    // R2 exit on either condition
    sup_lo_batt = 0; step(2);
    sup_lo_batt = 1; step(2);
    sup_lo_rst = 0; step(2);
    sys_rst = 0; mr_in_n = 1; step(3);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0) sys_rst = ~sys_rst;
      if ($urandom_range(0, 15) == 0) sup_lo_rst = ~sup_lo_rst;
      if ($urandom_range(0, 15) == 0) sup_lo_batt = ~sup_lo_batt;
      if ($urandom_range(0, 7) == 0) sup_lo_4v = ~sup_lo_4v;
      ce_in_n = 1'($urandom_range(0, 1));
      mr_in_n = 1'($urandom_range(0, 1));
      wdi_in = 1'($urandom_range(0, 1));
      pfo_in = 1'($urandom_range(0, 1));
      bok_in = 1'($urandom_range(0, 1));
      lowline_in = 1'($urandom_range(0, 1));
      step(1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(TCLK * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual hang expected finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule